// File: doc/BRIEF.md
# Reservation Table Collision Analyzer

This block works out which issue distances between two operations would collide in a pipeline. It holds a reservation table with one row for each pipeline stage and one column for each time slot. A set bit means that the stage is occupied in that slot. Software or a neighbouring controller loads the table one row at a time, then pulses a start strobe.

The block then steps through every offset K from 1 to the slot count minus one, spending one clock on each. For each offset it lays the table over a copy of itself shifted K slots later and checks whether any occupied cell lines up with another. When it finds such a cell, K is a forbidden latency and the matching bit of the collision vector is set. Otherwise K is allowed and the bit stays clear. After the last offset a done flag rises. The flag and the vector hold until the next accepted start.

A scheduler reads the collision vector to decide how soon a second operation may follow the first. Offsets beyond the table width need no check, because no operation stays in the pipeline longer than the table is wide.

Top module: `rsv_collide_top`

## Requirements
- R1: After reset, `busy`, `done` and every bit of `coll_vec` are 0.
- R2: While the block is not busy, a cycle with `row_we` high stores `row_bits` as the row of stage `row_sel`. Bit t of `row_bits` is time slot t. The other rows are left unchanged.
- R3: After a run, bit K-1 of `coll_vec` is 1 exactly when some stage has both slot t and slot t-K occupied, for some t. This holds for each K from 1 to 7.
- R4: A table with no occupied cell produces a `coll_vec` of all zeros.
- R5: A `start` sampled while not busy makes `busy` high from the next cycle. `done` rises on the 8th rising edge that counts the start edge as the first, which is 7 cycles after `busy` rises. On that same edge `busy` falls.
- R6: `done` and `coll_vec` hold their values until the next accepted `start`. That start clears `done` and `coll_vec` on its edge.
- R7: Row writes that arrive while `busy` is high are ignored and do not change the table used by later runs.
- R8: A `start` that arrives while `busy` is high is ignored. The run in progress keeps its timing and its result.
- R9: Only offsets 1 to 7 are evaluated. A stage occupied in all 8 slots marks every latency forbidden.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| row_we | input | 1 | Row write enable |
| row_sel | input | 2 | Stage index of the row being written |
| row_bits | input | 8 | Occupancy of the stage, bit t = time slot t |
| start | input | 1 | Start strobe for an analysis run |
| busy | output | 1 | High while offsets are being evaluated |
| done | output | 1 | High after the last offset until the next start |
| coll_vec | output | 7 | Bit K-1 set when latency K is forbidden |

## Verification
The assertions assume that `start` and `row_we` are synchronous single-bit strobes with no unknown values once reset is released. They also assume that the table changes only through the row port. The bench drives every input at the falling edge and keeps it constant across the rising edge. It pulses `start` for exactly one cycle, except in the deliberate cases of a start or a write during a run. It reads `busy`, `done` and `coll_vec` at the falling edge one half-period after the edge that updates them.

// File: rtl/rca_pkg.sv
package rca_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } rca_state_t;
endpackage

// File: rtl/rca_table.sv
module rca_table #(
  parameter int STAGES = 4,
  parameter int SLOTS  = 8,
  localparam int SW    = (STAGES > 1) ? $clog2(STAGES) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic                      lock,
  input  logic [SW-1:0]             sel,
  input  logic [SLOTS-1:0]          bits,
  output logic [STAGES*SLOTS-1:0]   flat
);
  logic [SLOTS-1:0] mem [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) mem[s] <= '0;
    end else if (we && !lock) begin
      mem[sel] <= bits;
    end
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_flat
    assign flat[g*SLOTS +: SLOTS] = mem[g];
  end

  // R7: the table is frozen while an analysis run holds the lock
  p_table_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    lock |=> $stable(flat));
endmodule

// File: rtl/rca_overlap.sv
module rca_overlap #(
  parameter int STAGES = 4,
  parameter int SLOTS  = 8,
  localparam int KW    = $clog2(SLOTS)
) (
  input  logic [STAGES*SLOTS-1:0] flat,
  input  logic [KW-1:0]           k,
  output logic                    hit
);
  logic [STAGES-1:0] stage_hit;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [SLOTS-1:0] row;
    logic [SLOTS-1:0] shifted;
    assign row       = flat[g*SLOTS +: SLOTS];
    assign shifted   = row << k;
    assign stage_hit[g] = |(row & shifted);
  end

  assign hit = |stage_hit;
endmodule

// File: rtl/rca_sequencer.sv
module rca_sequencer
  import rca_pkg::*;
#(
  parameter int SLOTS = 8,
  localparam int KW   = $clog2(SLOTS),
  localparam int LAT  = SLOTS - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          eval,
  output logic          clear,
  output logic [KW-1:0] k
);
  rca_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      k     <= KW'(1);
    end else begin
      case (state)
        ST_RUN: begin
          if (k == KW'(LAT)) state <= ST_FIN;
          else               k     <= k + KW'(1);
        end
        default: begin
          if (start) begin
            state <= ST_RUN;
            k     <= KW'(1);
          end
        end
      endcase
    end
  end

  assign busy  = (state == ST_RUN);
  assign done  = (state == ST_FIN);
  assign eval  = busy;
  assign clear = start && !busy;

  // R9: only offsets 1..LAT are visited
  p_k_range_r9: assert property (@(posedge clk) disable iff (rst)
    busy |-> (k >= KW'(1)) && (k <= KW'(LAT)));
  // R5: the last offset is followed by done
  p_done_after_last_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && k == KW'(LAT)) |=> (done && !busy));
  // R6: done holds without a start
  p_done_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);
  // R8: a run keeps stepping whatever start does
  p_run_steps_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && k != KW'(LAT)) |=> (busy && k == $past(k) + KW'(1)));
endmodule

// File: rtl/rca_result.sv
module rca_result #(
  parameter int SLOTS = 8,
  localparam int KW   = $clog2(SLOTS),
  localparam int LAT  = SLOTS - 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clear,
  input  logic           eval,
  input  logic [KW-1:0]  k,
  input  logic           hit,
  output logic [LAT-1:0] vec
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      vec <= '0;
    end else if (eval) begin
      for (int i = 0; i < LAT; i++) begin
        if (k == KW'(i + 1)) vec[i] <= hit;
      end
    end
  end

  // R6: the vector holds outside a run
  p_vec_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!eval && !clear) |=> $stable(vec));
  // R6: an accepted start empties the vector
  p_vec_clear_r6: assert property (@(posedge clk) disable iff (rst)
    clear |=> (vec == '0));
endmodule

// File: rtl/rsv_collide_top.sv
module rsv_collide_top #(
  parameter int STAGES = 4,
  parameter int SLOTS  = 8,
  localparam int SW    = (STAGES > 1) ? $clog2(STAGES) : 1,
  localparam int KW    = $clog2(SLOTS),
  localparam int LAT   = SLOTS - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             row_we,
  input  logic [SW-1:0]    row_sel,
  input  logic [SLOTS-1:0] row_bits,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic [LAT-1:0]   coll_vec
);
  logic [STAGES*SLOTS-1:0] flat;
  logic                    eval;
  logic                    clear;
  logic [KW-1:0]           k;
  logic                    hit;

  rca_table #(.STAGES(STAGES), .SLOTS(SLOTS)) u_table (
    .clk(clk), .rst(rst), .we(row_we), .lock(busy),
    .sel(row_sel), .bits(row_bits), .flat(flat)
  );

  rca_sequencer #(.SLOTS(SLOTS)) u_seq (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .eval(eval), .clear(clear), .k(k)
  );

  rca_overlap #(.STAGES(STAGES), .SLOTS(SLOTS)) u_ovl (
    .flat(flat), .k(k), .hit(hit)
  );

  rca_result #(.SLOTS(SLOTS)) u_res (
    .clk(clk), .rst(rst), .clear(clear), .eval(eval),
    .k(k), .hit(hit), .vec(coll_vec)
  );

  // R1: nothing is reported while reset is held
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !done && coll_vec == '0));
endmodule

// File: tb/test_rsv_collide_top.sv
module test_rsv_collide_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       row_we;
  logic [1:0] row_sel;
  logic [7:0] row_bits;
  logic       start;
  logic       busy;
  logic       done;
  logic [6:0] coll_vec;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;
  logic [7:0] ref_tab [4];

  always #4 clk = ~clk;

  rsv_collide_top i_rsv_collide_top (
    .clk(clk), .rst(rst), .row_we(row_we), .row_sel(row_sel),
    .row_bits(row_bits), .start(start), .busy(busy), .done(done),
    .coll_vec(coll_vec)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [6:0] model();
    logic [6:0] v = '0;
    for (int kk = 1; kk < 8; kk++)
      for (int s = 0; s < 4; s++)
        for (int t = kk; t < 8; t++)
          if (ref_tab[s][t] && ref_tab[s][t-kk]) v[kk-1] = 1'b1;
    return v;
  endfunction

  task automatic load_row(int s, logic [7:0] b);
    @(negedge clk);
    row_we = 1'b1; row_sel = 2'(s); row_bits = b;
    @(negedge clk);
    row_we = 1'b0;
    ref_tab[s] = b;
  endtask

  task automatic clear_tab();
    for (int s = 0; s < 4; s++) load_row(s, 8'h00);
  endtask

  // poke: 0 none, 1 row write mid-run, 2 start mid-run
  task automatic run_check(string req, int poke);
    logic [6:0] exp = model();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({req, " busy after start (R5)"}, {7'd0, busy}, 8'd1);
    check({req, " done cleared by start (R6)"}, {7'd0, done}, 8'd0);
    for (int n = 1; n <= 6; n++) begin
      if (n == 3 && poke == 1) begin row_we = 1'b1; row_sel = 2'd0; row_bits = 8'hFF; end
      if (n == 3 && poke == 2) start = 1'b1;
      @(negedge clk);
      row_we = 1'b0; start = 1'b0;
      if (n == 6) check({req, " done not early (R5)"}, {7'd0, done}, 8'd0);
    end
    @(negedge clk);
    check({req, " done on time (R5)"}, {6'd0, done, busy}, 8'b10);
    check({req, " collision vector (R3)"}, {1'b0, coll_vec}, {1'b0, exp});
  endtask

  task automatic t_reset();
    check("R1 busy", {7'd0, busy}, 8'd0);
    check("R1 done", {7'd0, done}, 8'd0);
    check("R1 vec", {1'b0, coll_vec}, 8'd0);
  endtask

  task automatic t_zero();
    clear_tab();
    run_check("R4 zero table", 0);
    check("R4 all clear", {1'b0, coll_vec}, 8'd0);
  endtask

  task automatic t_ends();
    clear_tab();
    load_row(2, 8'b1000_0001);
    run_check("R3 ends only", 0);
    check("R3 only K=7", {1'b0, coll_vec}, 8'b0100_0000);
  endtask

  task automatic t_mixed();
    clear_tab();
    load_row(0, 8'b0000_0011);
    load_row(1, 8'b0000_0100);
    load_row(2, 8'b0001_1000);
    load_row(3, 8'b0010_0001);
    run_check("R2 mixed rows", 0);
    check("R2 mixed K=1,5", {1'b0, coll_vec}, 8'b0001_0001);
  endtask

  task automatic t_full();
    clear_tab();
    load_row(1, 8'hFF);
    run_check("R9 full row", 0);
    check("R9 all forbidden", {1'b0, coll_vec}, 8'h7F);
  endtask

  task automatic t_write_busy();
    clear_tab();
    load_row(0, 8'b0000_0101);
    run_check("R7 write mid-run", 1);
    run_check("R7 table unchanged", 0);
    check("R7 K=2 only", {1'b0, coll_vec}, 8'b0000_0010);
  endtask

  task automatic t_start_busy();
    clear_tab();
    load_row(3, 8'b0100_1001);
    run_check("R8 start mid-run", 2);
    @(negedge clk);
    check("R8 no restart", {6'd0, done, busy}, 8'b10);
  endtask

  task automatic t_hold();
    logic [6:0] v = coll_vec;
    repeat (10) @(negedge clk);
    load_row(0, 8'hFF);
    check("R6 done held", {7'd0, done}, 8'd1);
    check("R6 vec held", {1'b0, coll_vec}, {1'b0, v});
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    rst = 1'b1; row_we = 1'b0; row_sel = '0; row_bits = '0; start = 1'b0;
    for (int s = 0; s < 4; s++) ref_tab[s] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_zero();
    t_ends();
    t_mixed();
    t_full();
    t_write_busy();
    t_start_busy();
    t_hold();
    finish_up();
  end
endmodule